// File: doc/BRIEF.md
# Gated Edge-Count Frequency Meter

This block measures the frequency of a fast input whose edges bear no relation to the system clock. A counter clocked by the measured signal itself counts rising edges. The system-clock logic reaches it at one point only: an enable on that counter, which passes through a two-stage synchronizer clocked by the measured signal. A sequencer in the system domain first clears the counter. It then opens the enable for a fixed window and closes it again. After a settle interval, by which time the count can no longer move, it copies the count into a system-domain register. The cycle then repeats.

Every number that crosses the domain boundary is static when it is sampled, so no Gray coding and no handshake are needed. The clear reaches the counter as an asynchronous clear driven from a system-domain flop. It is applied only while the enable is closed, so the counter is never both counting and clearing. Each new result appears on the output with a one-cycle valid pulse. The result stays unchanged until the next pulse.

With the default window of 200,000,000 system cycles (one second at 200 MHz), the output reads directly in hertz. The default settle time is 2,000 cycles (10 µs).

Top module: `fc_gated_freq_counter`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after that edge, `count_out` is 0 and `count_valid` is 0. This holds even if a measurement was in progress.
- R2: Each published `count_out` equals, to within ±1, the number of rising edges of `sig_in` that fall inside a gate window of `WINDOW_CYC` system cycles. This holds for inputs both slower and faster than `clk`.
- R3: `count_valid` is high for exactly one cycle per result. `count_out` changes only in the cycle in which `count_valid` is high, and holds its value in every other cycle.
- R4: Measurement rounds repeat with a fixed spacing of `CLEAR_CYC + WINDOW_CYC + SETTLE_CYC + 1` system cycles between consecutive `count_valid` pulses. The gate opens in the cycle the clear ends, and it is closed during the settle interval and the capture cycle.
- R5: The counter is cleared after every capture, and the clear is never active while the gate is open. A round in which `sig_in` has no edges therefore publishes 0, even when the previous round was nonzero.
- R6: The count is `CNT_W` bits wide (default 27) and wraps modulo 2^`CNT_W`. The published value is the edge count modulo 2^`CNT_W`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the gate window and settle interval are timed in its cycles |
| rst_n | input | 1 | Synchronous active-low reset of the system-domain logic |
| sig_in | input | 1 | Measured signal; its rising edges are counted and it clocks the counter |
| count_out | output | CNT_W | Most recent captured edge count |
| count_valid | output | 1 | One-cycle pulse marking a new value on `count_out` |

## Verification
The bench builds the block with `WINDOW_CYC = 100`, `SETTLE_CYC = 20` and `CLEAR_CYC = 4`, so one full round takes 125 cycles. At that size, many rounds with different input periods fit in a short run, including an input faster than the system clock and a stopped input. A second instance uses `CNT_W = 6`. With it, a 3 ns input overflows the counter within a single 500 ns window, which exercises the wrap behaviour that the 27-bit default could never reach.

// File: rtl/fc_pkg.sv
// Shared types for the gated frequency meter.
// Assumes nothing beyond a two-bit phase encoding.
package fc_pkg;
    typedef enum logic [1:0] {
        ST_CLEAR   = 2'd0,
        ST_GATE    = 2'd1,
        ST_SETTLE  = 2'd2,
        ST_CAPTURE = 2'd3
    } fc_phase_e;
endpackage

// File: rtl/fc_sync2.sv
// Two-stage synchronizer clocked by the measured signal.
// Assumes arst is asserted only while the synchronized input is low,
// so clearing the stages never shortens an open gate.
module fc_sync2 (
    input  logic smp_clk,
    input  logic arst,
    input  logic d,
    output logic q
);
    logic s1_q;

    // Two flops in series give metastability a full period to resolve
    always_ff @(posedge smp_clk or posedge arst) begin
        if (arst) begin
            s1_q <= 1'b0;
            q    <= 1'b0;
        end else begin
            s1_q <= d;
            q    <= s1_q;
        end
    end
endmodule

// File: rtl/fc_edge_counter.sv
// Counter running in the measured-signal domain. Its only gated point is
// the synchronized enable; the clear is asynchronous and is applied only
// while the enable is closed.
module fc_edge_counter #(
    parameter int unsigned CNT_W = 27
) (
    input  logic             sig_in,
    input  logic             gate_en,
    input  logic             cnt_clr,
    output logic [CNT_W-1:0] cnt_raw
);
    logic en_sync;

    fc_sync2 u_en_sync (
        .smp_clk (sig_in),
        .arst    (cnt_clr),
        .d       (gate_en),
        .q       (en_sync)
    );

    // Count rising edges of the input while the synchronized gate is open
    always_ff @(posedge sig_in or posedge cnt_clr) begin
        if (cnt_clr)      cnt_raw <= '0;
        else if (en_sync) cnt_raw <= cnt_raw + 1'b1;
    end
endmodule

// File: rtl/fc_sequencer.sv
// System-domain round sequencer: clear, gate, settle, capture, then repeat.
// Assumes every interval length is at least 1 cycle.
module fc_sequencer
    import fc_pkg::*;
#(
    parameter int unsigned WINDOW_CYC = 200_000_000,
    parameter int unsigned SETTLE_CYC = 2_000,
    parameter int unsigned CLEAR_CYC  = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic gate_en,
    output logic cnt_clr,
    output logic cap_stb
);
    localparam int unsigned LONG_A  = (WINDOW_CYC > SETTLE_CYC) ? WINDOW_CYC : SETTLE_CYC;
    localparam int unsigned LONGEST = (LONG_A > CLEAR_CYC) ? LONG_A : CLEAR_CYC;
    localparam int          TMR_W   = $clog2(LONGEST + 1);

    fc_phase_e        phase_q, phase_d;
    logic [TMR_W-1:0] tmr_q;
    logic             phase_end;

    // Decide when the current phase ends and which phase comes next
    always_comb begin
        phase_d   = phase_q;
        phase_end = 1'b0;
        case (phase_q)
            ST_CLEAR: begin
                phase_end = (tmr_q == TMR_W'(CLEAR_CYC - 1));
                if (phase_end) phase_d = ST_GATE;
            end
            ST_GATE: begin
                phase_end = (tmr_q == TMR_W'(WINDOW_CYC - 1));
                if (phase_end) phase_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                phase_end = (tmr_q == TMR_W'(SETTLE_CYC - 1));
                if (phase_end) phase_d = ST_CAPTURE;
            end
            default: begin
                phase_end = 1'b1;
                phase_d   = ST_CLEAR;
            end
        endcase
    end

    // Advance phase and timer; register gate and clear so they cannot glitch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= ST_CLEAR;
            tmr_q   <= '0;
            gate_en <= 1'b0;
            cnt_clr <= 1'b1;
        end else begin
            phase_q <= phase_d;
            tmr_q   <= phase_end ? '0 : tmr_q + 1'b1;
            gate_en <= (phase_d == ST_GATE);
            cnt_clr <= (phase_d == ST_CLEAR);
        end
    end

    assign cap_stb = (phase_q == ST_CAPTURE);
endmodule

// File: rtl/fc_capture.sv
// Copies the settled count into the system domain and pulses valid.
// Assumes cnt_raw is static whenever cap_stb is high.
module fc_capture #(
    parameter int unsigned CNT_W = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_stb,
    input  logic [CNT_W-1:0] cnt_raw,
    output logic [CNT_W-1:0] count_out,
    output logic             count_valid
);
    // Latch the count once per round and flag it for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_out   <= '0;
            count_valid <= 1'b0;
        end else begin
            count_valid <= cap_stb;
            if (cap_stb) count_out <= cnt_raw;
        end
    end
endmodule

// File: rtl/fc_gated_freq_counter.sv
// Top of the gated frequency meter. The counter runs on sig_in; the
// system domain reads it only after the gate has closed and settled.
// Assumes SETTLE_CYC spans more than two sig_in periods plus carry settling.
module fc_gated_freq_counter #(
    parameter int unsigned CNT_W      = 27,
    parameter int unsigned WINDOW_CYC = 200_000_000,
    parameter int unsigned SETTLE_CYC = 2_000,
    parameter int unsigned CLEAR_CYC  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_in,
    output logic [CNT_W-1:0] count_out,
    output logic             count_valid
);
    logic             gate_en;
    logic             cnt_clr;
    logic             cap_stb;
    logic [CNT_W-1:0] cnt_raw;

    fc_sequencer #(
        .WINDOW_CYC (WINDOW_CYC),
        .SETTLE_CYC (SETTLE_CYC),
        .CLEAR_CYC  (CLEAR_CYC)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .gate_en (gate_en),
        .cnt_clr (cnt_clr),
        .cap_stb (cap_stb)
    );

    fc_edge_counter #(.CNT_W(CNT_W)) u_cnt (
        .sig_in  (sig_in),
        .gate_en (gate_en),
        .cnt_clr (cnt_clr),
        .cnt_raw (cnt_raw)
    );

    fc_capture #(.CNT_W(CNT_W)) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_stb     (cap_stb),
        .cnt_raw     (cnt_raw),
        .count_out   (count_out),
        .count_valid (count_valid)
    );
endmodule

// File: rtl/fc_checker.sv
// Protocol checks for the gated frequency meter, bound to its top.
module fc_checker #(
    parameter int unsigned CNT_W = 27
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gate_en,
    input logic             cnt_clr,
    input logic             count_valid,
    input logic [CNT_W-1:0] count_out
);
    assert_valid_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count_valid |=> !count_valid);

    assert_hold_between_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !count_valid |-> $stable(count_out));

    assert_no_clear_in_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_en && cnt_clr));

    assert_clear_after_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(count_valid) |-> cnt_clr);

    assert_gate_follows_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnt_clr) |-> gate_en);

    assert_closed_before_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(count_valid) |-> !$past(gate_en));
endmodule

bind fc_gated_freq_counter fc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .gate_en     (gate_en),
    .cnt_clr     (cnt_clr),
    .count_valid (count_valid),
    .count_out   (count_out)
);

// File: tb/sim_fc_gated_freq_counter.sv
`timescale 1ns/1ps
module sim_fc_gated_freq_counter;
    localparam int unsigned WIN    = 100;
    localparam int unsigned SETTLE = 20;
    localparam int unsigned CLRC   = 4;
    localparam int          ROUND  = CLRC + WIN + SETTLE + 1;
    localparam int          WIN_PS = WIN * 5000;
    localparam int          NVEC   = 5;
    // Input periods in ps; 0 means the input is held low
    localparam int VEC_PER [0:NVEC-1] = '{7000, 13000, 3000, 37000, 0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sig_in = 1'b0;
    real         half_ns = 0.0;
    logic [26:0] cnt0;
    logic        val0;
    logic [5:0]  cnt1;
    logic        val1;
    int          checks = 0;
    int          failures = 0;

    always #2.5 clk = ~clk;

    // Measured-signal generator
    initial forever begin
        if (half_ns <= 0.0) begin
            sig_in = 1'b0;
            #1;
        end else begin
            #(half_ns) sig_in = ~sig_in;
        end
    end

    fc_gated_freq_counter #(.CNT_W(27), .WINDOW_CYC(WIN), .SETTLE_CYC(SETTLE), .CLEAR_CYC(CLRC)) u0 (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .count_out(cnt0), .count_valid(val0));

    fc_gated_freq_counter #(.CNT_W(6), .WINDOW_CYC(WIN), .SETTLE_CYC(SETTLE), .CLEAR_CYC(CLRC)) u1 (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .count_out(cnt1), .count_valid(val1));

    task automatic check(input string req, input int got, input int exp, input int tol, input int modulus);
        int d;
        d = got - exp;
        if (modulus > 0) begin
            d = ((d % modulus) + modulus) % modulus;
            if (d > modulus / 2) d = d - modulus;
        end
        checks++;
        if (d > tol || d < -tol) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic wait_valid();
        do @(negedge clk); while (!val0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int exp;
        int held_bad;
        int gap;
        // R1: outputs idle during reset
        repeat (4) @(negedge clk);
        check("R1 reset count", int'(cnt0), 0, 0, 0);
        check("R1 reset valid", int'(val0), 0, 0, 0);
        rst_n = 1'b1;

        // R2/R6: table of input periods, each judged on a round lying wholly in it
        for (int i = 0; i < NVEC; i++) begin
            half_ns = VEC_PER[i] / 2000.0;
            exp = (VEC_PER[i] == 0) ? 0 : WIN_PS / VEC_PER[i];
            wait_valid();
            wait_valid();
            check((VEC_PER[i] == 0) ? "R5 stopped input after nonzero" : "R2 edge count",
                  int'(cnt0), exp, (exp == 0) ? 0 : 1, 0);
            check("R6 wrap 6-bit", int'(cnt1), exp % 64, (exp == 0) ? 0 : 1, 64);
        end

        // R3/R4: pulse width, hold between pulses, spacing
        half_ns = 5.5;
        wait_valid();
        @(negedge clk);
        check("R3 valid width", int'(val0), 0, 0, 0);
        exp = int'(cnt0);
        held_bad = 0;
        gap = 1;
        while (!val0) begin
            if (int'(cnt0) != exp) held_bad++;
            @(negedge clk);
            gap++;
        end
        check("R3 hold between pulses", held_bad, 0, 0, 0);
        check("R4 round spacing", gap, ROUND, 0, 0);
        check("R2 11ns input", int'(cnt0), WIN_PS / 11000, 1, 0);

        // R1: reset in the middle of a gate window
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 mid-run count", int'(cnt0), 0, 0, 0);
        check("R1 mid-run valid", int'(val0), 0, 0, 0);
        rst_n = 1'b1;
        wait_valid();
        check("R5 first round after reset", int'(cnt0), WIN_PS / 11000, 1, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule